// File: doc/BRIEF.md
# Fractional Baud Rate Clock Generator

This block produces the bit timing for a serial transceiver. A down-counter with a reload value built from a 12-bit period setting and a signed 4-bit scale exponent emits a base tick. A non-negative scale multiplies the integer divider by a power of two. A negative scale turns on a small fractional accumulator, so that the divider advances in steps of 1/2^|scale| on average. The tick is routed to single-cycle transmit and receive enables, which stay in the peripheral clock domain, according to one of five clock modes.

In the two asynchronous modes the receive enable runs at the base tick rate, and the transmit enable is a divided copy of it (by 4, or by 2 at double speed). In synchronous master and SPI master modes the tick toggles an internal transfer clock. That clock is driven out on the pin, and the enables mark its two edges. In synchronous slave mode the internal generator is unused: the pin is synchronized, optionally inverted and edge-detected. A restart strobe, asserted whenever the period or scale is rewritten, clears the counter, the accumulator, the post-divider and the transfer clock. A combinational flag reports settings that are not allowed.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_n is low, tx_en and rx_en stay low and xck_out equals xck_inv.
- R2: With scale in 0..7 in an asynchronous mode (mode 0 or 1), rx_en pulses in the first cycle after a restart and then every (period+1)·2^scale cycles.
- R3: With scale in -7..-1 (a = -scale, F = period mod 2^a), the k-th gap between rx_en pulses after a restart is floor(period/2^a)+1 cycles. One extra cycle is added when floor(k·F/2^a) > floor((k-1)·F/2^a).
- R4: In mode 0 (normal asynchronous) tx_en coincides with the 1st, 5th, 9th… rx_en pulse after a restart. In mode 1 (double-speed asynchronous) it coincides with every odd-numbered one. tx_en never pulses without rx_en.
- R5: In mode 2 (synchronous master) and mode 4 (SPI master), xck_oe is high and each base tick toggles the transfer clock in the following cycle. rx_en marks ticks where the uninverted clock is low, and tx_en marks ticks where it is high. The two never coincide. Ticks are period+1 cycles apart for scale 0, and the first tick after a restart is an rx_en.
- R6: xck_inv flips the driven level: xck_out equals the internal clock XOR xck_inv. In slave mode the edges are detected on xck_in XOR xck_inv.
- R7: In mode 3 (synchronous slave), xck_oe is low and the internal generator produces no enables. A rising edge of (xck_in XOR xck_inv) that arrives before clock edge k gives a one-cycle rx_en between edges k+1 and k+2. A falling edge gives tx_en in the same way.
- R8: A restart strobe sampled at a clock edge makes the next cycle a tick, even if it lands in a tick cycle. In asynchronous modes that next cycle carries both rx_en and tx_en.
- R9: cfg_err is high when period is 0 and scale is non-zero. It is also high when 2^|scale| exceeds FRAME_MIN_CYC/2 (the default is 16, so |scale| ≥ 4, including the code 4'b1000), or when mode is above 4.
- R10: Modes 5 to 7 produce no enables and keep xck_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Restart strobe, asserted when period or scale is rewritten |
| mode | input | 3 | 0 async, 1 async double speed, 2 sync master, 3 sync slave, 4 SPI master |
| period | input | 12 | Integer period setting, 0..4095 |
| scale | input | 4 | Signed scale exponent, -7..+7 |
| xck_inv | input | 1 | Transfer clock pin inversion |
| xck_in | input | 1 | Transfer clock from the pin, asynchronous |
| xck_out | output | 1 | Transfer clock level to the pin |
| xck_oe | output | 1 | Pin drive enable (master modes) |
| tx_en | output | 1 | Single-cycle transmit shift enable |
| rx_en | output | 1 | Single-cycle receive sample enable |
| cfg_err | output | 1 | Illegal setting combination |

## Verification
Two events can fall in the same cycle. The first is a restart strobe landing in the very cycle the counter expires. The bench waits for an rx_en pulse and raises the strobe in that cycle. It then requires a fresh rx_en and tx_en in the next cycle, followed by a full period, which shows that the restart wins over the reload. The second is a restart in slave mode that coincides with a change of the external clock. Here the edge must still come out two cycles later as a single enable, because the restart leaves the synchronizer alone.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int PER_W         = 12,
  parameter int SCL_W         = 4,
  parameter int FRAME_MIN_CYC = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       mode,
  input  logic [PER_W-1:0] period,
  input  logic [SCL_W-1:0] scale,
  input  logic             xck_inv,
  input  logic             xck_in,
  output logic             xck_out,
  output logic             xck_oe,
  output logic             tx_en,
  output logic             rx_en,
  output logic             cfg_err
);
  localparam int MAX_SH = 2 ** (SCL_W - 1);
  localparam int CNT_W  = PER_W + MAX_SH;
  localparam int ACC_W  = MAX_SH;
  localparam logic [ACC_W:0] HALF_V = (ACC_W + 1)'(FRAME_MIN_CYC / 2);

  logic                   run;
  logic [CNT_W-1:0]       cnt;
  logic [ACC_W:0]         acc;
  logic [1:0]             div;
  logic                   xck_int;
  logic [SYNC_STAGES:0]   sync_q;

  wire is_async  = (mode == 3'd0) || (mode == 3'd1);
  wire is_master = (mode == 3'd2) || (mode == 3'd4);
  wire is_slave  = (mode == 3'd3);

  wire             neg = scale[SCL_W-1];
  wire [SCL_W-1:0] mag = neg ? -scale : scale;
  wire             tick = run && (cnt == '0);

  wire [CNT_W-1:0] per_ext    = CNT_W'(period);
  wire [CNT_W-1:0] reload_pos = ((per_ext + CNT_W'(1)) << mag) - CNT_W'(1);
  wire [ACC_W:0]   modulus    = (ACC_W + 1)'(1) << mag;
  wire [ACC_W:0]   frac       = (ACC_W + 1)'(period) & (modulus - (ACC_W + 1)'(1));
  wire [ACC_W:0]   acc_sum    = acc + frac;
  wire             carry      = acc_sum >= modulus;
  wire [ACC_W:0]   acc_nxt    = carry ? acc_sum - modulus : acc_sum;
  wire [CNT_W-1:0] reload_neg = (per_ext >> mag) + CNT_W'(carry);
  wire [1:0]       div_last   = (mode == 3'd1) ? 2'd1 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      div     <= '0;
      xck_int <= 1'b0;
    end else begin
      run <= 1'b1;
      if (cfg_wr) begin
        cnt     <= '0;
        acc     <= '0;
        div     <= '0;
        xck_int <= 1'b0;
      end else if (tick) begin
        if (neg) begin
          cnt <= reload_neg;
          acc <= acc_nxt;
        end else begin
          cnt <= reload_pos;
        end
        div <= (div >= div_last) ? 2'd0 : div + 2'd1;
        if (is_master) xck_int <= ~xck_int;
      end else if (run) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], xck_in};
  end

  wire pin_now  = sync_q[SYNC_STAGES-1] ^ xck_inv;
  wire pin_prev = sync_q[SYNC_STAGES] ^ xck_inv;
  wire s_rise   = pin_now & ~pin_prev;
  wire s_fall   = ~pin_now & pin_prev;

  assign rx_en = is_async  ? tick :
                 is_master ? (tick & ~xck_int) :
                 is_slave  ? s_rise : 1'b0;
  assign tx_en = is_async  ? (tick & (div == 2'd0)) :
                 is_master ? (tick & xck_int) :
                 is_slave  ? s_fall : 1'b0;
  assign xck_out = xck_int ^ xck_inv;
  assign xck_oe  = is_master;
  assign cfg_err = ((period == '0) && (scale != '0)) || (modulus > HALF_V) || (mode > 3'd4);

  AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master || is_slave) |-> !(tx_en && rx_en)); // R5
  AST_MASTER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && is_master && !cfg_wr) |=> (xck_int != $past(xck_int))); // R5
  AST_RESTART_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && is_async) |=> (rx_en || !is_async)); // R8
  AST_SLAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && rx_en) |=> (!rx_en || !is_slave)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cfg_wr && !neg) |-> (cnt <= reload_pos)); // R2
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  localparam int FRAME = 16;
  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0, xck_inv = 1'b0, xck_in = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [11:0] period = 12'd0;
  logic [3:0]  scale = 4'd0;
  wire xck_out, xck_oe, tx_en, rx_en, cfg_err;
  int checks = 0, fails = 0;

  frac_baud_gen #(.FRAME_MIN_CYC(FRAME)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .mode(mode), .period(period),
    .scale(scale), .xck_inv(xck_inv), .xck_in(xck_in), .xck_out(xck_out),
    .xck_oe(xck_oe), .tx_en(tx_en), .rx_en(rx_en), .cfg_err(cfg_err));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(int p, int s, int k);
    int a, f;
    if (s >= 0) return (p + 1) << s;
    a = -s;
    f = p % (1 << a);
    return (p >> a) + 1 + ((((k * f) >> a) > (((k - 1) * f) >> a)) ? 1 : 0);
  endfunction

  task automatic do_cfg(input int m, input int p, input int s, input logic inv);
    @(negedge clk);
    mode = m[2:0]; period = p[11:0]; scale = s[3:0]; xck_inv = inv; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_async(input int m, input int p, input int s, input int ngaps);
    int d, last, cyc, n;
    d = (m == 1) ? 2 : 4;
    last = 0; cyc = 0;
    do_cfg(m, p, s, 1'b0);
    chk("R8 tick after restart", rx_en, 1);
    chk("R4 tx after restart", tx_en, 1);
    n = 1;
    while (n <= ngaps) begin
      @(negedge clk);
      cyc++;
      if (rx_en) begin
        chk((s >= 0) ? "R2 gap" : "R3 gap", cyc - last, exp_gap(p, s, n));
        chk("R4 tx divide", tx_en, ((n % d) == 0) ? 1 : 0);
        last = cyc;
        n++;
      end else if (tx_en) begin
        chk("R4 tx without rx", 1, 0);
      end
    end
  endtask

  task automatic run_master(input int m, input int p, input logic inv, input int ncyc);
    int rxn, txn, last, first;
    logic prev_x, was;
    rxn = 0; txn = 0; last = 0; first = 1;
    do_cfg(m, p, 0, inv);
    chk("R5 oe high", xck_oe, 1);
    chk("R5 first tick is rx", rx_en, 1);
    was = 1'b0; prev_x = xck_out;
    for (int c = 0; c < ncyc; c++) begin
      if (was) chk("R5 toggle after tick", xck_out, int'(!prev_x));
      else     chk("R5 hold between ticks", xck_out, int'(prev_x));
      if (rx_en) begin chk("R6 level at rx", xck_out, int'(inv)); rxn++; end
      if (tx_en) begin chk("R6 level at tx", xck_out, int'(!inv)); txn++; end
      if (rx_en || tx_en) begin
        if (!first) chk("R5 tick spacing", c - last, p + 1);
        first = 0; last = c;
      end
      was = rx_en | tx_en; prev_x = xck_out;
      @(negedge clk);
    end
    chk("R5 rx/tx alternate", ((rxn - txn) == 0 || (rxn - txn) == 1) ? 1 : 0, 1);
  endtask

  task automatic slave_edge(input logic lvl, input logic inv, input logic with_wr);
    int up;
    up = (lvl ^ inv) ? 1 : 0;
    @(negedge clk);
    xck_in = lvl;
    cfg_wr = with_wr;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R7 no pulse after one edge", rx_en | tx_en, 0);
    @(negedge clk);
    chk("R7 rx pulse", rx_en, up);
    chk("R7 tx pulse", tx_en, 1 - up);
    @(negedge clk);
    chk("R7 pulse ends", rx_en | tx_en, 0);
  endtask

  initial begin
    #(20 * 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p, s, m;
    void'($urandom(32'd2024));
    repeat (3) begin
      @(negedge clk);
      chk("R1 rx in reset", rx_en, 0);
      chk("R1 tx in reset", tx_en, 0);
      chk("R1 pin level", xck_out, int'(xck_inv));
    end
    xck_inv = 1'b1;
    #1 chk("R1 pin level inverted", xck_out, 1);
    xck_inv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    run_async(0, 4095, 0, 2);
    run_async(0, 4095, -7, 6);
    run_async(0, 0, 0, 9);
    run_async(1, 5, 3, 4);
    run_async(1, 13, -2, 9);
    run_async(0, 7, -3, 10);
    for (int i = 0; i < 20; i++) begin
      m = $urandom % 2;
      s = int'($urandom % 7) - 3;
      p = int'($urandom % 60) + 1;
      run_async(m, p, s, 6);
    end

    do_cfg(0, 3, 0, 1'b0);
    repeat (5) @(negedge clk);
    while (!rx_en) @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R8 restart in tick cycle rx", rx_en, 1);
    chk("R8 restart in tick cycle tx", tx_en, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R8 quiet after restart", rx_en, 0);
    end
    @(negedge clk);
    chk("R8 next tick one period later", rx_en, 1);

    run_master(2, 2, 1'b0, 40);
    run_master(4, 0, 1'b1, 20);
    run_master(2, 5, 1'b1, 50);

    for (int v = 0; v < 2; v++) begin
      do_cfg(3, 1, 0, v[0]);
      chk("R7 oe low", xck_oe, 0);
      for (int c = 0; c < 20; c++) begin
        chk("R7 no internal enables", rx_en | tx_en, 0);
        @(negedge clk);
      end
      slave_edge(1'b1, v[0], 1'b0);
      slave_edge(1'b0, v[0], 1'b1);
      slave_edge(1'b1, v[0], 1'b0);
      slave_edge(1'b0, v[0], 1'b0);
    end

    do_cfg(5, 1, 0, 1'b0);
    for (int c = 0; c < 20; c++) begin
      chk("R10 no enables", rx_en | tx_en, 0);
      chk("R10 oe low", xck_oe, 0);
      @(negedge clk);
    end
    chk("R9 err mode 5", cfg_err, 1);

    @(negedge clk);
    cfg_wr = 1'b1; mode = 3'd0;
    period = 12'd0; scale = 4'd1;  #1 chk("R9 zero period nonzero scale", cfg_err, 1);
    period = 12'd0; scale = 4'd0;  #1 chk("R9 zero period zero scale", cfg_err, 0);
    period = 12'd9; scale = 4'd3;  #1 chk("R9 scale 3 allowed", cfg_err, 0);
    period = 12'd9; scale = 4'd4;  #1 chk("R9 scale 4 too large", cfg_err, 1);
    period = 12'd9; scale = 4'hD;  #1 chk("R9 scale -3 allowed", cfg_err, 0);
    period = 12'd9; scale = 4'hC;  #1 chk("R9 scale -4 too large", cfg_err, 1);
    period = 12'd9; scale = 4'h8;  #1 chk("R9 code 1000 flagged", cfg_err, 1);
    scale = 4'd0; mode = 3'd6;     #1 chk("R9 mode 6 flagged", cfg_err, 1);
    mode = 3'd4;                   #1 chk("R9 mode 4 legal", cfg_err, 0);
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule